// File: doc/BRIEF.md
# GPIO Dual-Status Edge Interrupt Controller

This block watches a bank of already-synchronized GPIO inputs and turns their transitions into interrupts. Every pin has a polarity bit that chooses which edge counts as its "assert" event. The opposite edge counts as its "deassert" event. The two kinds of event are latched in two separate pending registers. Each register drives its own interrupt line, so software can service activations and releases through different handlers.

Software reaches the block through a plain register port. The port has a one-cycle write strobe and a combinational read. The configuration registers (enable and polarity) hold 32 pins per 32-bit word. The two pending registers hold 31 pins per word: bit 0 of every pending word is reserved, and pins occupy bits 31:1. Pending bits are cleared by writing ones to them. An interrupt line rises only for pins whose enable bit is set. A pending bit is still recorded for a pin whose enable bit is clear.

Register select codes on `wr_sel_i` and `rd_sel_i`:
- 0 selects enable.
- 1 selects polarity.
- 2 selects assert-pending.
- 3 selects deassert-pending.

Top module: `gpio_dual_edge_irq`

## Requirements
- R1: After reset every enable, polarity and pending bit reads 0, and both interrupt outputs are low.
- R2: With a pin's polarity bit at 1, a rising edge on the pin sets its assert-pending bit and a falling edge sets its deassert-pending bit. The bit is readable on the clock edge after the edge is sampled.
- R3: With a pin's polarity bit at 0, a falling edge sets its assert-pending bit and a rising edge sets its deassert-pending bit.
- R4: In both pending registers, pin p is at word p/31, bit (p mod 31)+1. Bit 0 of a pending word always reads 0, and writing it has no effect.
- R5: In the enable and polarity registers, pin p is at word p/32, bit p mod 32. A write replaces the addressed word. Reads return the stored bits. Bits and words beyond the last pin read 0.
- R6: Writing a 1 to a pending bit (select 2 or 3) clears it. Writing a 0 leaves it unchanged.
- R7: If a clear and a new event for the same pending bit fall in the same cycle, the bit ends up set.
- R8: `irq_assert_o` (`irq_deassert_o`) is a register that goes high one clock after any pin has both its enable bit and its assert-pending (deassert-pending) bit set. Pins with a clear enable bit never contribute.
- R9: Pending bits latch whether or not the pin is enabled. Enabling a pin whose bit is already pending raises the interrupt.
- R10: Events come only from changes on the pin inputs. Changing a polarity bit while the pin is steady creates no event.
- R11: The first clock edge after reset only captures the pin levels and records no event, whatever levels the pins held during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized GPIO levels |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 2 | Register select for the write |
| wr_word_i | input | IDX_W | Word index for the write |
| wr_data_i | input | 32 | Write data (ones clear bits in pending registers) |
| rd_sel_i | input | 2 | Register select for the read |
| rd_word_i | input | IDX_W | Word index for the read |
| rd_data_o | output | 32 | Combinational read data |
| irq_assert_o | output | 1 | Registered OR of enabled assert-pending bits |
| irq_deassert_o | output | 1 | Registered OR of enabled deassert-pending bits |

## Verification
A pin level driven before clock edge N shows up as a pending bit on the read port after edge N. A pending bit reaches an interrupt line after edge N+1. A register write presented before edge N is readable after edge N, and it affects the interrupt lines after edge N+1. The bench drives every input just after a falling edge and updates its reference model at the rising edge, using the pre-edge state. It then compares both interrupt lines and every readable word at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register select codes shared by the write and read ports
  typedef enum logic [1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_POLARITY = 2'd1,
    SEL_ASSERT   = 2'd2,
    SEL_DEASSERT = 2'd3
  } reg_sel_e;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned CFG_PER_W  = 32;  // pins per enable/polarity word
  localparam int unsigned STAT_PER_W = 31;  // pins per pending word (bit 0 reserved)

  function automatic int unsigned words_for(input int unsigned pins, input int unsigned per_word);
    return (pins + per_word - 1) / per_word;
  endfunction

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] polarity_i,
  output logic [NPINS-1:0] assert_ev_o,
  output logic [NPINS-1:0] deassert_ev_o
);

  logic [NPINS-1:0] prev_q;
  logic             primed_q;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] fall;

  // Previous level; the primed flag masks the very first comparison after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    rise = pin_i & ~prev_q & {NPINS{primed_q}};
    fall = ~pin_i & prev_q & {NPINS{primed_q}};
  end

  // Polarity picks which edge is the assert event for each pin
  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      always_comb begin
        if (polarity_i[p]) begin
          assert_ev_o[p]   = rise[p];
          deassert_ev_o[p] = fall[p];
        end else begin
          assert_ev_o[p]   = fall[p];
          deassert_ev_o[p] = rise[p];
        end
      end
    end
  endgenerate

  // R10
  no_event_when_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pin_i) |-> ((assert_ev_o | deassert_ev_o) == '0));

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 40,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IDX_W-1:0] wr_word_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  input  logic [IDX_W-1:0] rd_word_i,
  output logic [NPINS-1:0] enable_o,
  output logic [NPINS-1:0] polarity_o,
  output logic [REG_W-1:0] rd_data_o
);

  localparam int unsigned NWORDS = words_for(NPINS, CFG_PER_W);

  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic [REG_W-1:0] en_words  [NWORDS];
  logic [REG_W-1:0] pol_words [NWORDS];

  genvar p, w, b;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      localparam int unsigned WI = p / CFG_PER_W;
      localparam int unsigned BI = p % CFG_PER_W;
      logic hit;
      assign hit = wr_en_i && (wr_word_i == IDX_W'(WI));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q[p]  <= 1'b0;
          pol_q[p] <= 1'b0;
        end else if (hit) begin
          if (wr_sel_i == SEL_ENABLE)   en_q[p]  <= wr_data_i[BI];
          if (wr_sel_i == SEL_POLARITY) pol_q[p] <= wr_data_i[BI];
        end
      end
    end

    // Readback words; slots past the last pin read 0
    for (w = 0; w < NWORDS; w++) begin : g_word
      for (b = 0; b < CFG_PER_W; b++) begin : g_bit
        if (w * CFG_PER_W + b < NPINS) begin : g_used
          assign en_words[w][b]  = en_q[w * CFG_PER_W + b];
          assign pol_words[w][b] = pol_q[w * CFG_PER_W + b];
        end else begin : g_pad
          assign en_words[w][b]  = 1'b0;
          assign pol_words[w][b] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (rd_word_i == IDX_W'(i)) begin
        if (rd_sel_i == SEL_ENABLE)   rd_data_o = en_words[i];
        if (rd_sel_i == SEL_POLARITY) rd_data_o = pol_words[i];
      end
    end
  end

  assign enable_o   = en_q;
  assign polarity_o = pol_q;

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i;

endmodule

// File: rtl/gpio_event_status.sv
module gpio_event_status
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 40,
  parameter int unsigned IDX_W = 2,
  parameter logic [1:0]  MYSEL = SEL_ASSERT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] enable_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IDX_W-1:0] wr_word_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_word_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);

  localparam int unsigned NWORDS = words_for(NPINS, STAT_PER_W);

  logic [NPINS-1:0] stat_q;
  logic [NPINS-1:0] clr;
  logic [REG_W-1:0] words [NWORDS];
  logic             irq_q;

  genvar p, w, b;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      localparam int unsigned WI = p / STAT_PER_W;
      localparam int unsigned BI = p % STAT_PER_W + 1;
      assign clr[p] = wr_en_i && (wr_sel_i == MYSEL) &&
                      (wr_word_i == IDX_W'(WI)) && wr_data_i[BI];
    end

    for (w = 0; w < NWORDS; w++) begin : g_word
      assign words[w][0] = 1'b0;  // reserved
      for (b = 1; b < REG_W; b++) begin : g_bit
        if (w * STAT_PER_W + b - 1 < NPINS) begin : g_used
          assign words[w][b] = stat_q[w * STAT_PER_W + b - 1];
        end else begin : g_pad
          assign words[w][b] = 1'b0;
        end
      end
    end
  endgenerate

  // New events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | set_i;
      irq_q  <= |(stat_q & enable_i);
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (rd_word_i == IDX_W'(i)) rd_data_o = words[i];
    end
  end

  assign irq_o = irq_q;

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i;

  // R7
  event_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R6
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0));

  // R8
  disabled_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i == '0) |=> !irq_o);

endmodule

// File: rtl/gpio_dual_edge_irq.sv
module gpio_dual_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 40,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IDX_W-1:0] wr_word_i,
  input  logic [31:0]      wr_data_i,
  input  logic [1:0]       rd_sel_i,
  input  logic [IDX_W-1:0] rd_word_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_assert_o,
  output logic             irq_deassert_o
);

  logic [NPINS-1:0] enable;
  logic [NPINS-1:0] polarity;
  logic [NPINS-1:0] assert_ev;
  logic [NPINS-1:0] deassert_ev;
  logic [REG_W-1:0] cfg_rd;
  logic [REG_W-1:0] ast_rd;
  logic [REG_W-1:0] dst_rd;

  gpio_pin_cfg #(.NPINS(NPINS), .IDX_W(IDX_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_word_i  (wr_word_i),
    .wr_data_i  (wr_data_i),
    .rd_sel_i   (rd_sel_i),
    .rd_word_i  (rd_word_i),
    .enable_o   (enable),
    .polarity_o (polarity),
    .rd_data_o  (cfg_rd)
  );

  gpio_edge_detect #(.NPINS(NPINS)) u_edge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pin_i         (pin_i),
    .polarity_i    (polarity),
    .assert_ev_o   (assert_ev),
    .deassert_ev_o (deassert_ev)
  );

  gpio_event_status #(.NPINS(NPINS), .IDX_W(IDX_W), .MYSEL(SEL_ASSERT)) u_ast (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (assert_ev),
    .enable_i  (enable),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_word_i (wr_word_i),
    .wr_data_i (wr_data_i),
    .rd_word_i (rd_word_i),
    .rd_data_o (ast_rd),
    .irq_o     (irq_assert_o)
  );

  gpio_event_status #(.NPINS(NPINS), .IDX_W(IDX_W), .MYSEL(SEL_DEASSERT)) u_dst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (deassert_ev),
    .enable_i  (enable),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_word_i (wr_word_i),
    .wr_data_i (wr_data_i),
    .rd_word_i (rd_word_i),
    .rd_data_o (dst_rd),
    .irq_o     (irq_deassert_o)
  );

  always_comb begin
    unique case (rd_sel_i)
      SEL_ASSERT:   rd_data_o = ast_rd;
      SEL_DEASSERT: rd_data_o = dst_rd;
      default:      rd_data_o = cfg_rd;
    endcase
  end

  // R4
  reserved_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == SEL_ASSERT || rd_sel_i == SEL_DEASSERT) |-> !rd_data_o[0]);

endmodule

// File: tb/tb_gpio_dual_edge_irq.sv
`timescale 1ns/10ps
module tb_gpio_dual_edge_irq;
  localparam int NP = 40;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins = '1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [IW-1:0] wr_word = '0, rd_word = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq_a, irq_d;

  int nchk = 0, nfail = 0;
  logic done = 1'b0;

  // reference model state
  logic [NP-1:0] en_m = '0, pol_m = '0, sa_m = '0, sd_m = '0, prev_m = '0;
  logic primed_m = 1'b0, ia_m = 1'b0, id_m = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_dual_edge_irq #(.NPINS(NP), .IDX_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_word_i(wr_word), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .irq_assert_o(irq_a), .irq_deassert_o(irq_d)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int s, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int p;
      if (s < 2) begin
        p = w * 32 + b;
        if (p < NP) r[b] = (s == 0) ? en_m[p] : pol_m[p];
      end else if (b > 0) begin
        p = w * 31 + b - 1;
        if (p < NP) r[b] = (s == 2) ? sa_m[p] : sd_m[p];
      end
    end
    return r;
  endfunction

  task automatic rd(input int s, input int w, output logic [31:0] d);
    rd_sel = s[1:0];
    rd_word = w[IW-1:0];
    #0.1;
    d = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    chk({tag, " R8 irq_assert"}, {31'd0, irq_a}, {31'd0, ia_m});
    chk({tag, " R8 irq_deassert"}, {31'd0, irq_d}, {31'd0, id_m});
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        rd(s, w, d);
        chk($sformatf("%s R4/R5 sel%0d word%0d", tag, s, w), d, exp_word(s, w));
      end
  endtask

  task automatic model_step();
    logic [NP-1:0] rise, fall, ea, ed, ca, cd;
    logic na, nd;
    na = |(sa_m & en_m);
    nd = |(sd_m & en_m);
    rise = primed_m ? (pins & ~prev_m) : '0;
    fall = primed_m ? (~pins & prev_m) : '0;
    ea = (rise & pol_m) | (fall & ~pol_m);
    ed = (fall & pol_m) | (rise & ~pol_m);
    ca = '0; cd = '0;
    if (wr_en) begin
      for (int p = 0; p < NP; p++) begin
        if (wr_sel == 0 && p / 32 == int'(wr_word)) en_m[p] = wr_data[p % 32];
        if (wr_sel == 1 && p / 32 == int'(wr_word)) pol_m[p] = wr_data[p % 32];
        if (wr_sel == 2 && p / 31 == int'(wr_word)) ca[p] = wr_data[p % 31 + 1];
        if (wr_sel == 3 && p / 31 == int'(wr_word)) cd[p] = wr_data[p % 31 + 1];
      end
    end
    sa_m = (sa_m & ~ca) | ea;
    sd_m = (sd_m & ~cd) | ed;
    prev_m = pins;
    primed_m = 1'b1;
    ia_m = na;
    id_m = nd;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(input int s, input int w, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s[1:0]; wr_word = w[IW-1:0]; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    cyc();  // pins held high through reset: no event
    rd(2, 0, d); chk("R11 assert word0", d, 32'h0);
    rd(3, 1, d); chk("R11 deassert word1", d, 32'h0);
    check_all("R11");

    wr(1, 1, 32'h81);
    rd(1, 1, d); chk("R5 polarity word1", d, 32'h81);
    rd(1, 2, d); chk("R5 unmapped word", d, 32'h0);

    pins[31] = 1'b0; cyc();
    rd(2, 1, d); chk("R3 pin31 fall -> assert word1 bit1", d, 32'h2);
    check_all("R3");

    pins[32] = 1'b0; cyc();
    rd(3, 1, d); chk("R2 pin32 fall -> deassert word1 bit2", d, 32'h4);
    pins[32] = 1'b1; cyc();
    rd(2, 1, d); chk("R2 pin32 rise -> assert word1 bit2", d, 32'h6);

    wr(2, 1, 32'h1);
    rd(2, 1, d); chk("R4 bit0 write ignored", d, 32'h6);
    wr(2, 1, 32'h0);
    rd(2, 1, d); chk("R6 write zero keeps", d, 32'h6);
    wr(2, 1, 32'h2);
    rd(2, 1, d); chk("R6 write one clears", d, 32'h4);
    chk("R9 pending but disabled irq low", {31'd0, irq_a}, 32'h0);

    wr(0, 1, 32'h1);
    chk("R8 irq not yet", {31'd0, irq_a}, 32'h0);
    cyc();
    chk("R9 enable raises irq_assert", {31'd0, irq_a}, 32'h1);

    wr(3, 1, 32'h4);
    rd(3, 1, d); chk("R6 deassert cleared", d, 32'h0);
    pins[32] = 1'b0;
    wr(3, 1, 32'h4);
    rd(3, 1, d); chk("R7 set beats clear", d, 32'h4);
    check_all("R7");

    wr(1, 1, 32'h83);
    cyc();
    rd(2, 1, d); chk("R10 no assert on polarity change", d & 32'h8, 32'h0);
    rd(3, 1, d); chk("R10 no deassert on polarity change", d & 32'h8, 32'h0);
    check_all("R10");

    for (int i = 0; i < 600; i++) begin
      pins = pins ^ {$urandom(), $urandom()} & {$urandom(), $urandom()};
      if ($urandom_range(3) == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom_range(3));
        wr_word = IW'($urandom_range(3));
        wr_data = $urandom();
      end
      cyc();
      wr_en = 1'b0;
      check_all("R2/R3 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule